// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches over system software by comparing a free-running 64-bit system count against a stored deadline. Software arms it by setting the enable bit. It then keeps it quiet by refreshing it. Any write to the refresh frame, any write to the control word, or a write to the period register while the block runs moves the deadline to the current count plus the programmed period. If the deadline passes without a refresh, the first stage raises a level interrupt and the block moves the deadline one period further on. If that second deadline also passes, the block raises a reset request. The reset request stays set until the block itself is reset, so software can find out after reboot that the watchdog caused the reset.

Registers sit in two frames, each with its own simple 32-bit write strobe and combinational read port. The control frame holds the control word, the period and the deadline. The refresh frame holds only the refresh register. Both frames carry an identification word that reports the version. The version is a parameter and sets how wide the period register is: 32 bits in version 0, 48 bits in version 1.

Top module: `dual_wdog`

## Requirements
- R1: After reset the control word reads 0, both stage outputs are low, and the period and deadline registers read 0.
- R2: A write of any data to refresh-frame address 0x000 sets the deadline to count+period and clears the first-stage flag while enabled.
- R3: Any write to control address 0x000 is a refresh. Its bit 0 becomes the enable, so writing 0 stops the watchdog.
- R4: A write to the period words (0x008 low, 0x00C high) refreshes using the new period only while enabled; while disabled it only stores the period and the deadline is unchanged.
- R5: When enabled and count >= deadline with the first-stage flag clear, the first-stage flag sets and the deadline becomes count+period.
- R6: When enabled and count >= deadline with the first-stage flag set, the reset request sets; it survives refreshes and disabling until block reset.
- R7: In version 1 the period is 48 bits: 0x00C holds bits 47:32 in its bits 15:0 and its upper 16 bits read zero. In version 0 the period is 32 bits and 0x00C reads zero and ignores writes.
- R8: Address 0xFCC in both frames reads the identification word: the version in bits 19:16 and zero elsewhere.
- R9: The deadline reads at 0x010 (bits 31:0) and 0x014 (bits 63:32) and can be written there; such a write is not a refresh.
- R10: While disabled, neither stage flag can newly set, and refreshes leave the status bits unchanged.
- R11: The control word reads enable at bit 0, the first-stage flag at bit 1 and the reset request at bit 2; writes to bits 1 and 2 are ignored, and the outputs equal these flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_cnt | input | 64 | Free-running system count |
| ctl_we | input | 1 | Control frame write strobe |
| ctl_addr | input | 12 | Control frame byte address |
| ctl_wdata | input | 32 | Control frame write data |
| ctl_rdata | output | 32 | Control frame read data |
| rfr_we | input | 1 | Refresh frame write strobe |
| rfr_addr | input | 12 | Refresh frame byte address |
| rfr_wdata | input | 32 | Refresh frame write data (value ignored) |
| rfr_rdata | output | 32 | Refresh frame read data |
| stage1_irq | output | 1 | First-stage expiry level |
| stage2_rst_req | output | 1 | Sticky reset request |

## Verification
The count is held at chosen values so that each deadline can be placed one count before, at, and after expiry. This separates the compare from a strict greater-than and shows that each stage moves the deadline. The bench refreshes from the refresh frame, from the control word and from the period words, both enabled and disabled, and in the same state each time. This shows which writes re-arm the deadline and which only store a value. A random phase writes random 48-bit periods at random counts and checks each new deadline against the expected sum. It catches wrong word placement and truncation of the high period bits.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int unsigned REG_AW  = 12;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned CNT_W   = 64;

    localparam logic [REG_AW-1:0] A_CTRL    = 12'h000;
    localparam logic [REG_AW-1:0] A_PER_LO  = 12'h008;
    localparam logic [REG_AW-1:0] A_PER_HI  = 12'h00C;
    localparam logic [REG_AW-1:0] A_DL_LO   = 12'h010;
    localparam logic [REG_AW-1:0] A_DL_HI   = 12'h014;
    localparam logic [REG_AW-1:0] A_KICK    = 12'h000;
    localparam logic [REG_AW-1:0] A_IDENT   = 12'hFCC;

    // write events decoded from both frames for one cycle
    typedef struct packed {
        logic              kick;
        logic              ctl_wr;
        logic              en_val;
        logic              per_lo_wr;
        logic              per_hi_wr;
        logic              dl_lo_wr;
        logic              dl_hi_wr;
        logic [DATA_W-1:0] data;
    } wdg_cmd_t;

    typedef struct packed {
        logic stage2;
        logic stage1;
        logic enable;
    } wdg_stat_t;

    function automatic int unsigned per_width(int unsigned ver);
        return (ver == 0) ? 32 : 48;
    endfunction

    function automatic logic [DATA_W-1:0] ident_word(int unsigned ver);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[19:16] = 4'(ver);
        return w;
    endfunction

endpackage

// File: rtl/wdg_decode.sv
module wdg_decode
    import wdg_pkg::*;
#(
    parameter int unsigned VERSION = 1
) (
    input  logic              ctl_we,
    input  logic [REG_AW-1:0] ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              rfr_we,
    input  logic [REG_AW-1:0] rfr_addr,
    input  logic              en_q,
    output wdg_cmd_t          cmd
);
    localparam bit HAS_HI = (per_width(VERSION) > DATA_W);

    logic per_any;

    always_comb begin
        cmd           = '0;
        cmd.data      = ctl_wdata;
        cmd.ctl_wr    = ctl_we && (ctl_addr == A_CTRL);
        cmd.en_val    = ctl_wdata[0];
        cmd.per_lo_wr = ctl_we && (ctl_addr == A_PER_LO);
        cmd.per_hi_wr = HAS_HI && ctl_we && (ctl_addr == A_PER_HI);
        cmd.dl_lo_wr  = ctl_we && (ctl_addr == A_DL_LO);
        cmd.dl_hi_wr  = ctl_we && (ctl_addr == A_DL_HI);
        per_any       = cmd.per_lo_wr || cmd.per_hi_wr;
        cmd.kick      = (rfr_we && (rfr_addr == A_KICK)) || cmd.ctl_wr
                        || (per_any && en_q);
    end

endmodule

// File: rtl/wdg_period.sv
module wdg_period
    import wdg_pkg::*;
#(
    parameter int unsigned VERSION = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  per_q,
    output logic [CNT_W-1:0]  per_nx
);
    localparam int unsigned PW  = per_width(VERSION);
    localparam int unsigned HIW = PW - DATA_W;

    logic [DATA_W-1:0] lo_q, lo_nx;

    always_comb lo_nx = lo_wr ? data : lo_q;

    always_ff @(posedge clk) begin
        if (rst) lo_q <= '0;
        else     lo_q <= lo_nx;
    end

    generate
        if (HIW > 0) begin : g_wide
            logic [HIW-1:0] hi_q, hi_nx;
            always_comb hi_nx = hi_wr ? data[HIW-1:0] : hi_q;
            always_ff @(posedge clk) begin
                if (rst) hi_q <= '0;
                else     hi_q <= hi_nx;
            end
            assign per_q  = {{(CNT_W-PW){1'b0}}, hi_q, lo_q};
            assign per_nx = {{(CNT_W-PW){1'b0}}, hi_nx, lo_nx};
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = hi_wr;
            assign per_q  = {{(CNT_W-DATA_W){1'b0}}, lo_q};
            assign per_nx = {{(CNT_W-DATA_W){1'b0}}, lo_nx};
        end
    endgenerate

endmodule

// File: rtl/wdg_stage.sv
module wdg_stage
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] sys_cnt,
    input  wdg_cmd_t         cmd,
    input  logic [CNT_W-1:0] per_q,
    input  logic [CNT_W-1:0] per_nx,
    output wdg_stat_t        stat_q,
    output logic [CNT_W-1:0] dl_q
);
    logic expired;

    always_comb expired = stat_q.enable && (sys_cnt >= dl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            dl_q   <= '0;
        end else begin
            if (cmd.ctl_wr) stat_q.enable <= cmd.en_val;
            if (cmd.kick) begin
                // refresh wins over a same-cycle expiry
                dl_q <= sys_cnt + per_nx;
                if (stat_q.enable) stat_q.stage1 <= 1'b0;
            end else if (cmd.dl_lo_wr || cmd.dl_hi_wr) begin
                if (cmd.dl_lo_wr) dl_q[31:0]  <= cmd.data;
                if (cmd.dl_hi_wr) dl_q[63:32] <= cmd.data;
            end else if (expired) begin
                if (!stat_q.stage1) begin
                    stat_q.stage1 <= 1'b1;
                    dl_q          <= sys_cnt + per_q;
                end else begin
                    stat_q.stage2 <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/dual_wdog.sv
module dual_wdog
    import wdg_pkg::*;
#(
    parameter int unsigned VERSION = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              ctl_we,
    input  logic [REG_AW-1:0] ctl_addr,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    input  logic              rfr_we,
    input  logic [REG_AW-1:0] rfr_addr,
    input  logic [DATA_W-1:0] rfr_wdata,
    output logic [DATA_W-1:0] rfr_rdata,
    output logic              stage1_irq,
    output logic              stage2_rst_req
);
    localparam logic [DATA_W-1:0] ID_VAL = ident_word(VERSION);

    wdg_cmd_t         cmd;
    wdg_stat_t        stat_q;
    logic [CNT_W-1:0] per_q, per_nx, dl_q;
    logic             en_q;
    logic             unused_rfr;

    assign unused_rfr = ^rfr_wdata;
    assign en_q       = stat_q.enable;

    wdg_decode #(.VERSION(VERSION)) u_dec (
        .ctl_we   (ctl_we),
        .ctl_addr (ctl_addr),
        .ctl_wdata(ctl_wdata),
        .rfr_we   (rfr_we),
        .rfr_addr (rfr_addr),
        .en_q     (en_q),
        .cmd      (cmd)
    );

    wdg_period #(.VERSION(VERSION)) u_per (
        .clk   (clk),
        .rst   (rst),
        .lo_wr (cmd.per_lo_wr),
        .hi_wr (cmd.per_hi_wr),
        .data  (cmd.data),
        .per_q (per_q),
        .per_nx(per_nx)
    );

    wdg_stage u_stg (
        .clk    (clk),
        .rst    (rst),
        .sys_cnt(sys_cnt),
        .cmd    (cmd),
        .per_q  (per_q),
        .per_nx (per_nx),
        .stat_q (stat_q),
        .dl_q   (dl_q)
    );

    always_comb begin
        case (ctl_addr)
            A_CTRL:   ctl_rdata = {{(DATA_W-3){1'b0}}, stat_q};
            A_PER_LO: ctl_rdata = per_q[31:0];
            A_PER_HI: ctl_rdata = per_q[63:32];
            A_DL_LO:  ctl_rdata = dl_q[31:0];
            A_DL_HI:  ctl_rdata = dl_q[63:32];
            A_IDENT:  ctl_rdata = ID_VAL;
            default:  ctl_rdata = '0;
        endcase
        rfr_rdata = (rfr_addr == A_IDENT) ? ID_VAL : '0;
    end

    assign stage1_irq     = stat_q.stage1;
    assign stage2_rst_req = stat_q.stage2;

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic        clk,
    input logic        rst,
    input logic        en_q,
    input logic        ws0,
    input logic        ws1,
    input logic        rfr_we,
    input logic [11:0] rfr_addr
);
    // R6: reset request is sticky
    assert_sticky_req_R6: assert property (@(posedge clk) disable iff (rst)
        ws1 |=> ws1);

    // R6: second stage only follows a set first stage
    assert_second_after_first_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ws1) |-> $past(ws0));

    // R5: first stage only rises while enabled
    assert_first_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ws0) |-> $past(en_q));

    // R10: nothing newly asserts while disabled
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !$rose(ws0) && !$rose(ws1));

    // R2: refresh-frame write while enabled clears first stage
    assert_kick_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (rfr_we && rfr_addr == 12'h000 && en_q) |=> !ws0);
endmodule

bind dual_wdog wdg_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_q    (en_q),
    .ws0     (stage1_irq),
    .ws1     (stage2_rst_req),
    .rfr_we  (rfr_we),
    .rfr_addr(rfr_addr)
);

// File: tb/tb_dual_wdog.sv
`timescale 1ns/1ps
module tb_dual_wdog;
    localparam int unsigned VER = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] sys_cnt = '0;
    logic        ctl_we = 1'b0;
    logic [11:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic        rfr_we = 1'b0;
    logic [11:0] rfr_addr = '0;
    logic [31:0] rfr_wdata = '0;
    logic [31:0] rfr_rdata;
    logic        ws0, ws1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_wdog #(.VERSION(VER)) dut (
        .clk(clk), .rst(rst), .sys_cnt(sys_cnt),
        .ctl_we(ctl_we), .ctl_addr(ctl_addr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .rfr_we(rfr_we), .rfr_addr(rfr_addr), .rfr_wdata(rfr_wdata), .rfr_rdata(rfr_rdata),
        .stage1_irq(ws0), .stage2_rst_req(ws1)
    );

    function automatic logic [63:0] exp_deadline(logic [63:0] cnt, logic [15:0] hi, logic [31:0] lo);
        return cnt + {16'h0, hi, lo};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cw(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        ctl_we = 1'b1; ctl_addr = a; ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic kick(logic [31:0] d);
        @(negedge clk);
        rfr_we = 1'b1; rfr_addr = 12'h000; rfr_wdata = d;
        @(negedge clk);
        rfr_we = 1'b0;
    endtask

    task automatic cr(logic [11:0] a, output logic [31:0] d);
        ctl_addr = a;
        #0.5;
        d = ctl_rdata;
    endtask

    task automatic rd_dl(output logic [63:0] d);
        logic [31:0] lo, hi;
        cr(12'h010, lo);
        cr(12'h014, hi);
        d = {hi, lo};
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] dl;
        void'($urandom(32'h5eed));
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        cr(12'h000, r); chk("R1 ctrl", r, 0);
        chk("R1 ws0", ws0, 0);
        chk("R1 ws1", ws1, 0);
        cr(12'h008, r); chk("R1 period", r, 0);
        rd_dl(dl); chk("R1 deadline", dl, 0);

        // R8 identification in both frames
        cr(12'hFCC, r); chk("R8 ctl ident", r, 32'h0001_0000);
        rfr_addr = 12'hFCC; #0.5; chk("R8 rfr ident", rfr_rdata, 32'h0001_0000);
        rfr_addr = 12'h000;

        // R7 high word width, R4 disabled period write is no refresh
        sys_cnt = 64'd777;
        cw(12'h00C, 32'hFFFF_FFFF);
        cr(12'h00C, r); chk("R7 period hi masked", r, 32'h0000_FFFF);
        cr(12'h008, r); chk("R7 period lo untouched", r, 0);
        rd_dl(dl); chk("R4 no refresh while off", dl, 0);

        // R9 deadline direct write, R10 no expiry while disabled
        cw(12'h010, 32'h1234);
        cw(12'h014, 32'h5);
        rd_dl(dl); chk("R9 deadline rw", dl, 64'h5_0000_1234);
        sys_cnt = 64'h7_0000_0000;
        tick(3);
        chk("R10 no ws0 when off", ws0, 0);
        rd_dl(dl); chk("R9 write not refresh", dl, 64'h5_0000_1234);

        // R3 enable write refreshes
        cw(12'h00C, 0);
        cw(12'h008, 100);
        sys_cnt = 64'd1000;
        cw(12'h000, 1);
        rd_dl(dl); chk("R3 enable refresh", dl, 1100);
        cr(12'h000, r); chk("R11 enabled word", r, 1);

        // R5 boundary: one below, then equal
        sys_cnt = 64'd1099; tick(2);
        chk("R5 no early expiry", ws0, 0);
        sys_cnt = 64'd1100; tick(1);
        chk("R5 ws0 at deadline", ws0, 1);
        rd_dl(dl); chk("R5 deadline advanced", dl, 1200);
        cr(12'h000, r); chk("R11 ws0 bit", r, 3);

        // R2 refresh frame clears stage one
        sys_cnt = 64'd1150;
        kick(32'hDEAD_BEEF);
        chk("R2 ws0 cleared", ws0, 0);
        rd_dl(dl); chk("R2 deadline", dl, 1250);

        // R6 second stage
        sys_cnt = 64'd1250; tick(1);
        chk("R5 ws0 again", ws0, 1);
        sys_cnt = 64'd1349; tick(1);
        chk("R6 no early ws1", ws1, 0);
        sys_cnt = 64'd1350; tick(1);
        chk("R6 ws1 set", ws1, 1);
        cr(12'h000, r); chk("R11 all bits", r, 7);
        kick(0);
        chk("R6 ws1 survives refresh", ws1, 1);
        chk("R2 ws0 cleared again", ws0, 0);

        // R3 stop, R10 disabled behaviour, R11 status writes ignored
        cw(12'h000, 0);
        cr(12'h000, r); chk("R3 stopped", r, 4);
        sys_cnt = 64'hFFFF_0000_0000_0000; tick(4);
        chk("R10 ws0 stays low", ws0, 0);
        kick(5);
        cr(12'h000, r); chk("R10 refresh off keeps status", r, 4);
        cw(12'h000, 32'h6);
        cr(12'h000, r); chk("R11 status bits read only", r, 4);

        // R4 period write while enabled refreshes with new period
        sys_cnt = 64'd5000;
        cw(12'h000, 1);
        rd_dl(dl); chk("R3 re-enable", dl, 5100);
        sys_cnt = 64'd5020;
        cw(12'h008, 40);
        rd_dl(dl); chk("R4 period refresh", dl, 5060);

        // random periods and counts
        for (int i = 0; i < 40; i++) begin
            logic [31:0] lo;
            logic [15:0] hi;
            logic [63:0] c;
            lo = $urandom() | 32'h1;
            hi = 16'($urandom());
            c  = {1'b0, 31'($urandom()), 32'($urandom())};
            sys_cnt = c;
            cw(12'h00C, {16'hA5A5, hi});
            cw(12'h008, lo);
            rd_dl(dl); chk("R4 R7 random deadline", dl, exp_deadline(c, hi, lo));
            chk("R2 random ws0 clear", ws0, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule